// File: doc/BRIEF.md
# PWM Duty Cycle Meter

This block watches a pulse-width-modulated input that is asynchronous to the system clock and reports, for each complete period, how many clock cycles the input spent high and how many it spent low. Both counts are held on the outputs so that an attached microcontroller can read them directly and do its own arithmetic.

The block also computes a signed duty figure on chip. It multiplies the high count by 220 and divides by the full period length in a shift-subtract divider that produces one bit per clock. It then subtracts 110, so a 50 % waveform reads as zero and the full range runs from −110 to +110. A one-cycle strobe marks each new result. A period is the span between two rising edges of the synchronised input.

If a period ends while the divider is still working, that period is dropped. This keeps the reported counts and the result consistent with each other.

Top module: `pwm_duty_meter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `hi_count`, `lo_count`, `duty` and `ovf` are zero and `duty_valid` is low.
- R2: A period ends at each rising edge of the input. For a reported period, `hi_count` equals the number of clock cycles the input was high and `lo_count` equals the number of cycles it was low.
- R3: The first rising edge after reset only starts measurement. The partial period before it is never reported.
- R4: `duty` equals floor(220 × hi / (hi + lo)) − 110, given as a 32-bit two's-complement value.
- R5: `duty_valid` is high for exactly one cycle per reported period. `duty`, `hi_count` and `lo_count` hold their values until the next period is latched.
- R6: A phase longer than 65535 cycles saturates its count at 65535, and `ovf` is reported high with that period. `ovf` is low for periods whose counts stayed below the limit.
- R7: A period that ends while a division is in progress is discarded. The latched counts stay unchanged, and the next result belongs to a later period.
- R8: An input held at a constant level produces no result strobe, and a zero-length period is never handed to the divider.
- R9: Every reported `duty` lies in −110 to +110. A period with one high cycle and 65535 low cycles reports −110 with `ovf` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Asynchronous PWM input |
| hi_count | output | 16 | High cycles of the last reported period |
| lo_count | output | 16 | Low cycles of the last reported period |
| ovf | output | 1 | A count of the last reported period saturated |
| duty | output | 32 | Signed scaled duty, −110 to +110 |
| duty_valid | output | 1 | One-cycle strobe for a new `duty` value |

## Verification
The bench tries balanced, mostly-high, mostly-low and uneven periods. These show whether the floor of the quotient and the −110 offset land exactly, and whether the sign of the result is correct. One period of a single high cycle followed by 65535 low cycles checks the bottom of the range at the edge of saturation. A phase longer than 65535 cycles checks the saturation itself and the `ovf` flag. A short period that ends inside a running division, followed by a distinct long period, shows whether the busy period is dropped. Constant-level input and the partial period after reset show whether measurement starts and stops at the right edges.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_OUT_W  = 32;
    localparam int DEF_SCALE  = 220;
    localparam int DEF_OFFSET = 110;

    typedef enum logic [1:0] {
        DIV_IDLE,
        DIV_RUN,
        DIV_POST
    } div_state_e;

    function automatic int quot_width(input int scale, input int cnt_w);
        return cnt_w + $clog2(scale + 1);
    endfunction
endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int CNT_W = pwm_duty_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic             rise,
    input  logic             hold,
    output logic [CNT_W-1:0] hi_lat,
    output logic [CNT_W-1:0] lo_lat,
    output logic             ovf_lat,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] hi_run;
    logic [CNT_W-1:0] lo_run;
    logic             ovf_run;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= '0;
            lo_run  <= '0;
            ovf_run <= 1'b0;
            armed   <= 1'b0;
            hi_lat  <= '0;
            lo_lat  <= '0;
            ovf_lat <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                if (armed && !hold) begin
                    hi_lat  <= hi_run;
                    lo_lat  <= lo_run;
                    ovf_lat <= ovf_run;
                    done    <= 1'b1;
                end
                armed   <= 1'b1;
                hi_run  <= CNT_W'(1);
                lo_run  <= '0;
                ovf_run <= 1'b0;
            end else if (level) begin
                if (hi_run == CNT_MAX) ovf_run <= 1'b1;
                else                   hi_run  <= hi_run + 1'b1;
            end else begin
                if (lo_run == CNT_MAX) ovf_run <= 1'b1;
                else                   lo_run  <= lo_run + 1'b1;
            end
        end
    end

    AST_HI_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (level && !rise && hi_run == CNT_MAX) |=> (hi_run == CNT_MAX && ovf_run)); // R6
    AST_LO_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (!level && lo_run == CNT_MAX) |=> (lo_run == CNT_MAX && ovf_run)); // R6
    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(hi_lat) && $stable(lo_lat) && !done)); // R7
    AST_FIRST_EDGE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (rise && !armed) |=> !done); // R3
endmodule

// File: rtl/pwm_duty_divider.sv
module pwm_duty_divider #(
    parameter int CNT_W  = pwm_duty_pkg::DEF_CNT_W,
    parameter int OUT_W  = pwm_duty_pkg::DEF_OUT_W,
    parameter int SCALE  = pwm_duty_pkg::DEF_SCALE,
    parameter int OFFSET = pwm_duty_pkg::DEF_OFFSET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             busy,
    output logic [OUT_W-1:0] duty,
    output logic             valid
);
    import pwm_duty_pkg::*;

    localparam int SUM_W = CNT_W + 1;
    localparam int DIV_W = quot_width(SCALE, CNT_W);
    localparam int STEP_W = $clog2(DIV_W);
    localparam logic signed [OUT_W-1:0] LOW_BOUND  = -OUT_W'(OFFSET);
    localparam logic signed [OUT_W-1:0] HIGH_BOUND = OUT_W'(SCALE - OFFSET);

    div_state_e          state;
    logic [DIV_W-1:0]    dvd;
    logic [SUM_W-1:0]    dsr;
    logic [SUM_W-1:0]    rem;
    logic [STEP_W-1:0]   step;
    logic [SUM_W:0]      trial;
    logic [SUM_W:0]      diff;
    logic                fits;

    always_comb begin
        trial = {rem, dvd[DIV_W-1]};
        diff  = trial - {1'b0, dsr};
        fits  = (trial >= {1'b0, dsr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DIV_IDLE;
            dvd   <= '0;
            dsr   <= '0;
            rem   <= '0;
            step  <= '0;
            duty  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                DIV_IDLE: begin
                    if (start) begin
                        dvd   <= DIV_W'(SCALE) * DIV_W'(hi);
                        dsr   <= SUM_W'(hi) + SUM_W'(lo);
                        rem   <= '0;
                        step  <= STEP_W'(DIV_W - 1);
                        state <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    if (fits) begin
                        rem <= diff[SUM_W-1:0];
                        dvd <= {dvd[DIV_W-2:0], 1'b1};
                    end else begin
                        rem <= trial[SUM_W-1:0];
                        dvd <= {dvd[DIV_W-2:0], 1'b0};
                    end
                    if (step == '0) state <= DIV_POST;
                    else            step  <= step - 1'b1;
                end
                DIV_POST: begin
                    duty  <= OUT_W'(dvd) - OUT_W'(OFFSET);
                    valid <= 1'b1;
                    state <= DIV_IDLE;
                end
                default: state <= DIV_IDLE;
            endcase
        end
    end

    assign busy = (state != DIV_IDLE);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R5
    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($signed(duty) >= LOW_BOUND && $signed(duty) <= HIGH_BOUND)); // R9
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (state == DIV_IDLE)); // R7
    AST_DUTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(duty)); // R5
endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter #(
    parameter int CNT_W  = pwm_duty_pkg::DEF_CNT_W,
    parameter int OUT_W  = pwm_duty_pkg::DEF_OUT_W,
    parameter int SCALE  = pwm_duty_pkg::DEF_SCALE,
    parameter int OFFSET = pwm_duty_pkg::DEF_OFFSET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    output logic [CNT_W-1:0] hi_count,
    output logic [CNT_W-1:0] lo_count,
    output logic             ovf,
    output logic [OUT_W-1:0] duty,
    output logic             duty_valid
);
    logic level;
    logic rise;
    logic period_done;
    logic div_busy;
    logic hold;
    logic nonzero;
    logic start;

    pwm_edge_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pwm_in),
        .level    (level),
        .rise     (rise)
    );

    assign hold = div_busy | period_done;

    pwm_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .rise    (rise),
        .hold    (hold),
        .hi_lat  (hi_count),
        .lo_lat  (lo_count),
        .ovf_lat (ovf),
        .done    (period_done)
    );

    assign nonzero = (hi_count != '0) || (lo_count != '0);
    assign start   = period_done & nonzero;

    pwm_duty_divider #(
        .CNT_W  (CNT_W),
        .OUT_W  (OUT_W),
        .SCALE  (SCALE),
        .OFFSET (OFFSET)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .hi    (hi_count),
        .lo    (lo_count),
        .busy  (div_busy),
        .duty  (duty),
        .valid (duty_valid)
    );

    AST_NO_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
        period_done |-> nonzero); // R8
    AST_RESULT_AFTER_PERIOD: assert property (@(posedge clk) disable iff (rst)
        period_done |=> div_busy); // R4
endmodule

// File: tb/pwm_duty_meter_test.sv
module pwm_duty_meter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_in = 1'b0;
    logic [15:0] hi_count;
    logic [15:0] lo_count;
    logic        ovf;
    logic [31:0] duty;
    logic        duty_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int nval = 0;
    logic [15:0] rec_hi [8];
    logic [15:0] rec_lo [8];
    logic [31:0] rec_duty [8];
    logic        rec_ovf [8];

    pwm_duty_meter uut (
        .clk        (clk),
        .rst        (rst),
        .pwm_in     (pwm_in),
        .hi_count   (hi_count),
        .lo_count   (lo_count),
        .ovf        (ovf),
        .duty       (duty),
        .duty_valid (duty_valid)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwm_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nval = 0;
    endtask

    task automatic step(input logic v);
        pwm_in = v;
        @(negedge clk);
        if (duty_valid) begin
            if (nval < 8) begin
                rec_hi[nval] = hi_count;
                rec_lo[nval] = lo_count;
                rec_duty[nval] = duty;
                rec_ovf[nval] = ovf;
            end
            nval = nval + 1;
        end
    endtask

    function automatic longint exp_duty(input longint h, input longint l);
        return (220 * h) / (h + l) - 110;
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        pwm_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 hi_count in reset", hi_count, 0);
        check("R1 valid in reset", duty_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 lo_count after reset", lo_count, 0);
        check("R1 duty after reset", duty, 0);
        check("R1 ovf after reset", ovf, 0);
    endtask

    task automatic measure(input int h, input int l, input string tag);
        longint eh, el;
        logic [31:0] held;
        do_reset();
        repeat (4) step(1'b0);
        for (int i = 0; i < h; i++) step(1'b1);
        for (int i = 0; i < l; i++) step(1'b0);
        check({tag, " R3 no result before period ends"}, nval, 0);
        for (int i = 0; i < 80 && nval == 0; i++) step(1'b1);
        eh = (h > 65535) ? 65535 : h;
        el = (l > 65535) ? 65535 : l;
        check({tag, " R5 one strobe"}, nval, 1);
        check({tag, " R2 high count"}, rec_hi[0], eh);
        check({tag, " R2 low count"}, rec_lo[0], el);
        check({tag, " R4 duty"}, $signed(rec_duty[0]), exp_duty(eh, el));
        check({tag, " R6 ovf"}, rec_ovf[0], (h > 65535 || l > 65535) ? 1 : 0);
        held = duty;
        step(1'b1);
        check({tag, " R5 strobe drops"}, duty_valid, 0);
        check({tag, " R5 duty holds"}, duty, held);
    endtask

    task automatic test_busy_drop();
        do_reset();
        repeat (4) step(1'b0);
        for (int i = 0; i < 10; i++) step(1'b1);
        for (int i = 0; i < 10; i++) step(1'b0);
        for (int i = 0; i < 2; i++) step(1'b1);
        for (int i = 0; i < 3; i++) step(1'b0);
        for (int i = 0; i < 5; i++) step(1'b1);
        check("R7 counts kept during division", hi_count, 10);
        for (int i = 0; i < 25; i++) step(1'b1);
        for (int i = 0; i < 50; i++) step(1'b0);
        for (int i = 0; i < 60; i++) step(1'b1);
        check("R7 two results only", nval, 2);
        check("R7 first result high", rec_hi[0], 10);
        check("R7 first result duty", $signed(rec_duty[0]), 0);
        check("R7 later period high", rec_hi[1], 30);
        check("R7 later period low", rec_lo[1], 50);
        check("R7 later period duty", $signed(rec_duty[1]), exp_duty(30, 50));
    endtask

    task automatic test_constant();
        do_reset();
        for (int i = 0; i < 300; i++) step(1'b1);
        check("R8 constant high gives no result", nval, 0);
        for (int i = 0; i < 300; i++) step(1'b0);
        check("R8 constant low gives no result", nval, 0);
        check("R8 duty untouched", duty, 0);
    endtask

    initial begin
        test_reset();
        measure(10, 10, "balanced");
        measure(3, 1, "mostly high");
        measure(1, 2, "short uneven");
        measure(7, 13, "mostly low");
        test_busy_drop();
        test_constant();
        measure(1, 65535, "R9 bottom");
        measure(66000, 10, "R6 saturate");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule